// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-load logic of a byte-programmable nonvolatile memory. It watches every byte write the host makes, given as a one-cycle strobe with an address and a data byte. It recognises two command sequences made of exact address/data pairs. The short three-byte sequence arms protection, and it also opens a single protected load. The six-byte sequence removes protection. The command bytes themselves are flagged so that the page buffer drops them.

Changes to the protection flag do not happen at the moment a sequence completes. They happen when the write controller reports the end of the following programming period. When protection is on, an ordinary write is refused: the controller still runs a full dummy programming period, but this block withholds permission to store any byte. The flag is held in a register that reset leaves alone, which models retention across power loss. It powers up cleared.

Top module: `wp_cmd_guard`

## Requirements
- R1: `protect_state` is 0 at power-up. Asserting `rst_n` never changes it. Reset returns the sequence matcher to idle and clears any pending change and any open session.
- R2: The arming sequence is three consecutive writes: data 0xAA at address 0x5555, data 0x55 at 0x2AAA, then data 0xA0 at 0x5555. Each of these bytes raises `suppress_byte` and keeps `commit_allowed` low in its strobe cycle.
- R3: After the arming sequence, `protect_state` becomes 1 in the cycle after the next `prog_done` pulse, even if no data byte was written in between. Before that pulse it keeps its old value.
- R4: The release sequence is six consecutive writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Every byte is suppressed. `protect_state` becomes 0 in the cycle after the next `prog_done`. Data written between the sequence and that pulse is committed.
- R5: While protected, a non-command write with no session open gives `commit_allowed`=0 and `suppress_byte`=0. A `prog_done` that closes such a dummy cycle leaves `protect_state` at 1.
- R6: While protected, data writes that follow a completed arming sequence get `commit_allowed`=1 until the next `prog_done`. After that pulse, plain writes are refused again.
- R7: While unprotected, every write that is not a matched command step gets `commit_allowed`=1.
- R8: A write that is not the expected next step returns the matcher to idle and is treated as plain data (`suppress_byte`=0). A later byte that would have continued the abandoned sequence is not matched.
- R9: A command step is accepted when it arrives at most `WIN_CYC` cycles after the previous write. If the gap is longer, the partial match is dropped and that write is judged from idle.
- R10: When a write and `prog_done` fall in the same cycle, the write is judged with the session and protection values held before that edge. A sequence completed by that write stays pending and takes effect at the following `prog_done`.
- R11: `suppress_byte` and `commit_allowed` are only ever high in a cycle with `wr_stb` high, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (does not touch the protection flag) |
| wr_stb | input | 1 | One-cycle pulse per host byte write |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | DW | Data byte of the write |
| prog_done | input | 1 | One-cycle pulse at the end of a programming period |
| protect_state | output | 1 | Current protection flag |
| commit_allowed | output | 1 | The byte on the bus in this strobe cycle may be stored |
| suppress_byte | output | 1 | The byte in this strobe cycle is a command step and must be dropped |

## Verification
Two functions can land in the same cycle: a byte being judged, and the end-of-programming pulse that closes the session and applies a pending protection change. The bench provokes this in two directed ways. In one, the final arming byte is written together with `prog_done`. In the other, a session data byte is written together with `prog_done`. It expects the old session to govern that byte and the new pending change to survive into the next period. The random phase also mixes command bytes, long gaps and end pulses freely, and compares every cycle against a bench model in which write effects override the closing pulse.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  // Matcher progress: K* shared by both sequences, U* only on the release path
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_U3, ST_U4, ST_U5
  } step_e;

  localparam logic [7:0] KEY_FIRST      = 8'hAA;
  localparam logic [7:0] KEY_SECOND     = 8'h55;
  localparam logic [7:0] OP_LOCK        = 8'hA0;
  localparam logic [7:0] OP_UNLOCK      = 8'h80;
  localparam logic [7:0] OP_UNLOCK_LAST = 8'h20;

  typedef struct packed {
    step_e nxt;
    logic  hit;
    logic  lock_done;
    logic  unlock_done;
  } step_res_t;

endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_guard_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int WIN_CYC = 64,
  parameter logic [AW-1:0] ADDR_HI = 15'h5555,
  parameter logic [AW-1:0] ADDR_LO = 15'h2AAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cmd_hit,
  output logic          lock_done,
  output logic          unlock_done
);

  localparam int GW = $clog2(WIN_CYC + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(WIN_CYC);

  // One step of the matcher: where a write at (a, d) leads from step cur
  function automatic step_res_t advance(step_e cur, logic [AW-1:0] a, logic [DW-1:0] d);
    step_res_t r;
    logic at_hi;
    logic at_lo;
    at_hi = (a == ADDR_HI);
    at_lo = (a == ADDR_LO);
    r = '{nxt: ST_IDLE, hit: 1'b0, lock_done: 1'b0, unlock_done: 1'b0};
    case (cur)
      ST_IDLE: if (at_hi && d == DW'(KEY_FIRST))  begin r.nxt = ST_K1; r.hit = 1'b1; end
      ST_K1:   if (at_lo && d == DW'(KEY_SECOND)) begin r.nxt = ST_K2; r.hit = 1'b1; end
      ST_K2: begin
        if (at_hi && d == DW'(OP_LOCK)) begin
          r.hit = 1'b1;
          r.lock_done = 1'b1;
        end else if (at_hi && d == DW'(OP_UNLOCK)) begin
          r.nxt = ST_U3;
          r.hit = 1'b1;
        end
      end
      ST_U3:   if (at_hi && d == DW'(KEY_FIRST))  begin r.nxt = ST_U4; r.hit = 1'b1; end
      ST_U4:   if (at_lo && d == DW'(KEY_SECOND)) begin r.nxt = ST_U5; r.hit = 1'b1; end
      ST_U5: begin
        if (at_hi && d == DW'(OP_UNLOCK_LAST)) begin
          r.hit = 1'b1;
          r.unlock_done = 1'b1;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

  step_e         stp_q;
  step_e         stp_eff;
  logic [GW-1:0] gap_q;
  logic          expired;
  step_res_t     res;

  assign expired = (gap_q == GAP_MAX);
  assign stp_eff = expired ? ST_IDLE : stp_q;
  assign res     = advance(stp_eff, wr_addr, wr_data);

  assign cmd_hit     = wr_stb & res.hit;
  assign lock_done   = wr_stb & res.lock_done;
  assign unlock_done = wr_stb & res.unlock_done;

  // Cycles since the last write, saturating at the window limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= GAP_MAX;
    else if (wr_stb)  gap_q <= '0;
    else if (!expired) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stp_q <= ST_IDLE;
    else if (wr_stb)  stp_q <= res.nxt;
    else if (expired) stp_q <= ST_IDLE;
  end

  assert_seq_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_done || unlock_done) |=> (stp_q == ST_IDLE));

  assert_mismatch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !cmd_hit) |=> (stp_q == ST_IDLE));

  assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !lock_done && !unlock_done) |=> (stp_q != ST_IDLE));

  assert_window_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && expired) |=> (stp_q == ST_IDLE));

  assert_gap_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (gap_q == '0));

endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_done,
  input  logic lock_done,
  input  logic unlock_done,
  output logic prot,
  output logic sess
);

  // Retained flag: powers up clear, never touched by rst_n
  logic prot_q = 1'b0;
  logic pend_lock_q;
  logic pend_unlock_q;
  logic sess_q;

  always_ff @(posedge clk) begin
    if (rst_n && prog_done) begin
      if (pend_lock_q)        prot_q <= 1'b1;
      else if (pend_unlock_q) prot_q <= 1'b0;
    end
  end

  // A sequence finished in this cycle outranks the closing pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lock_q   <= 1'b0;
      pend_unlock_q <= 1'b0;
      sess_q        <= 1'b0;
    end else if (lock_done) begin
      pend_lock_q   <= 1'b1;
      pend_unlock_q <= 1'b0;
      sess_q        <= 1'b1;
    end else if (unlock_done) begin
      pend_lock_q   <= 1'b0;
      pend_unlock_q <= 1'b1;
      sess_q        <= 1'b1;
    end else if (prog_done) begin
      pend_lock_q   <= 1'b0;
      pend_unlock_q <= 1'b0;
      sess_q        <= 1'b0;
    end
  end

  assign prot = prot_q;
  assign sess = sess_q;

  assert_lock_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && pend_lock_q) |=> prot_q);

  assert_unlock_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && pend_unlock_q) |=> !prot_q);

  assert_flag_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(prot_q));

  assert_session_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && !lock_done && !unlock_done) |=> !sess_q);

  assert_session_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_done || unlock_done) |=> sess_q);

endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int WIN_CYC = 64,
  parameter logic [AW-1:0] ADDR_HI = 15'h5555,
  parameter logic [AW-1:0] ADDR_LO = 15'h2AAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          prog_done,
  output logic          protect_state,
  output logic          commit_allowed,
  output logic          suppress_byte
);

  logic cmd_hit;
  logic lock_done;
  logic unlock_done;
  logic prot;
  logic sess;

  wp_seq_match #(
    .AW(AW), .DW(DW), .WIN_CYC(WIN_CYC), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_hit(cmd_hit), .lock_done(lock_done), .unlock_done(unlock_done)
  );

  wp_prot_state u_state (
    .clk(clk), .rst_n(rst_n), .prog_done(prog_done),
    .lock_done(lock_done), .unlock_done(unlock_done),
    .prot(prot), .sess(sess)
  );

  assign protect_state  = prot;
  assign suppress_byte  = cmd_hit;
  assign commit_allowed = wr_stb & ~cmd_hit & (~prot | sess);

  assert_refused_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !cmd_hit && prot && !sess) |-> !commit_allowed);

endmodule

// File: tb/wp_cmd_guard_tb_top.sv
`timescale 1ns/1ps
module wp_cmd_guard_tb_top;

  localparam int WIN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        protect_state, commit_allowed, suppress_byte;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model of the requirements
  int m_pos = 0;
  int m_since = WIN + 1;
  bit m_prot = 0, m_pl = 0, m_pu = 0, m_sess = 0;

  always #4 clk = ~clk;

  wp_cmd_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_done(prog_done), .protect_state(protect_state),
    .commit_allowed(commit_allowed), .suppress_byte(suppress_byte)
  );

  function automatic logic [14:0] step_addr(int k);
    return (k == 1 || k == 4) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] step_data(int k);
    case (k)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pos = 0; m_since = WIN + 1; m_pl = 0; m_pu = 0; m_sess = 0;
  endtask

  task automatic cyc(bit w, logic [14:0] a, logic [7:0] d, bit dn, string tag);
    int pos, np;
    bit hit, ld, ud;
    @(negedge clk);
    wr_stb = w; wr_addr = a; wr_data = d; prog_done = dn;
    #1;
    pos = (m_since > WIN) ? 0 : m_pos;
    hit = 0; ld = 0; ud = 0; np = 0;
    if (a == step_addr(pos) && d == step_data(pos)) begin
      hit = 1;
      if (pos == 5) ud = 1; else np = pos + 1;
    end else if (pos == 2 && a == 15'h5555 && d == 8'hA0) begin
      hit = 1; ld = 1;
    end
    chk(tag, int'(protect_state), int'(m_prot));
    chk(tag, int'(suppress_byte), int'(w && hit));
    chk(tag, int'(commit_allowed), int'(w && !hit && (!m_prot || m_sess)));
    @(posedge clk);
    if (dn) begin
      if (m_pl) m_prot = 1; else if (m_pu) m_prot = 0;
      m_pl = 0; m_pu = 0; m_sess = 0;
    end
    if (w) begin
      if (ld) begin m_pl = 1; m_pu = 0; m_sess = 1; end
      else if (ud) begin m_pu = 1; m_pl = 0; m_sess = 1; end
      m_pos = np; m_since = 1;
    end else if (m_since <= WIN) m_since++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, tag);
  endtask

  task automatic lock_seq(string tag);
    cyc(1, 15'h5555, 8'hAA, 0, tag);
    cyc(1, 15'h2AAA, 8'h55, 0, tag);
    cyc(1, 15'h5555, 8'hA0, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 chk("R1", int'(protect_state), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    model_reset();
    idle(1, "R1");

    cyc(1, 15'h0123, 8'h3C, 0, "R7");
    lock_seq("R2");
    idle(1, "R3");
    cyc(0, '0, '0, 1, "R3");
    idle(1, "R3");
    chk("R3", int'(protect_state), 1);

    cyc(1, 15'h0400, 8'h77, 0, "R5");
    cyc(0, '0, '0, 1, "R5");
    idle(1, "R5");

    lock_seq("R6");
    cyc(1, 15'h0440, 8'h11, 0, "R6");
    cyc(1, 15'h0441, 8'h12, 0, "R6");
    cyc(0, '0, '0, 1, "R6");
    cyc(1, 15'h0442, 8'h13, 0, "R6");

    cyc(1, 15'h5555, 8'hAA, 0, "R8");
    cyc(1, 15'h2AAA, 8'h55, 0, "R8");
    cyc(1, 15'h5555, 8'h11, 0, "R8");
    cyc(1, 15'h5555, 8'hA0, 0, "R8");
    cyc(1, 15'h5555, 8'hAA, 0, "R8");
    cyc(1, 15'h2AAB, 8'h55, 0, "R8");

    cyc(1, 15'h5555, 8'hAA, 0, "R9");
    idle(WIN - 1, "R9");
    cyc(1, 15'h2AAA, 8'h55, 0, "R9");
    idle(WIN - 1, "R9");
    cyc(1, 15'h5555, 8'hA0, 0, "R9");
    cyc(1, 15'h5555, 8'hAA, 0, "R9");
    idle(WIN, "R9");
    cyc(1, 15'h2AAA, 8'h55, 0, "R9");
    cyc(0, '0, '0, 1, "R9");

    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1", int'(protect_state), 1);
    repeat (2) @(negedge clk);
    chk("R1", int'(protect_state), 1);
    rst_n = 1'b1;
    model_reset();
    idle(1, "R1");

    for (int k = 0; k < 6; k++) cyc(1, step_addr(k), step_data(k), 0, "R4");
    cyc(1, 15'h0100, 8'h5A, 0, "R4");
    idle(1, "R4");
    cyc(0, '0, '0, 1, "R4");
    cyc(1, 15'h0101, 8'h5B, 0, "R4");
    chk("R4", int'(protect_state), 0);

    cyc(1, 15'h5555, 8'hAA, 0, "R10");
    cyc(1, 15'h2AAA, 8'h55, 0, "R10");
    cyc(1, 15'h5555, 8'hA0, 1, "R10");
    idle(1, "R10");
    cyc(0, '0, '0, 1, "R10");
    idle(1, "R10");
    lock_seq("R10");
    cyc(1, 15'h0200, 8'hC3, 1, "R10");
    cyc(1, 15'h0201, 8'hC4, 0, "R10");

    for (int i = 0; i < 4000; i++) begin
      bit w, dn;
      logic [14:0] a;
      logic [7:0] d;
      int ra, rd;
      w = ($urandom_range(0, 2) != 0);
      dn = ($urandom_range(0, 24) == 0);
      ra = $urandom_range(0, 3);
      a = (ra < 2) ? 15'h5555 : (ra == 2) ? 15'h2AAA : 15'($urandom);
      rd = $urandom_range(0, 5);
      case (rd)
        0: d = 8'hAA;
        1: d = 8'h55;
        2: d = 8'hA0;
        3: d = 8'h80;
        4: d = 8'h20;
        default: d = 8'($urandom);
      endcase
      if (!w) begin a = '0; d = '0; end
      cyc(w, a, d, dn, "R11");
      if (i % 700 == 699) idle(WIN + 2, "R11");
    end

    summary();
    $finish;
  end

endmodule